// File: doc/BRIEF.md
# Partitioned SIMD Compare and Reduce Unit

This combinational unit treats a 64-bit operand pair as eight byte lanes that can be merged into wider partitions at run time. A 7-bit gate vector says where partitions break. Each partition is one run of whole bytes, so the word holds between one partition of 64 bits and eight partitions of 8 bits. A 4-bit mode input picks the operation. Six modes are unsigned relations between the two operands. Three modes are reductions over the first operand only.

The result has one bit per byte lane. Every lane bit covered by a partition carries that partition's single-bit answer. A consumer can therefore read the answer from any lane of the partition, or use the vector directly as a byte-select mask. Per-lane equal and greater bits are chained from the top lane of each partition downward, so the most significant differing byte decides the magnitude. The partition answer is then spread upward across the partition's lanes.

Top module: `simd_part_cmp`

## Requirements
- R1: Lane j is operand bits [8j+7:8j]. Gate bit j (j = 0..6) set to 1 places a partition break between lane j and lane j+1. Set to 0, it joins those two lanes into the same partition.
- R2: Every result bit of a partition equals the same value. For a partition of lanes k..k+w-1, res_o[k+w-1:k] is all zeros or all ones.
- R3: Mode 0 gives 1 when the partition's bytes of a_i and b_i are equal as one 8w-bit value. Mode 1 gives the complement of mode 0.
- R4: Mode 2 gives a > b and mode 3 gives a >= b. Both compare the partition's 8w-bit slices as unsigned numbers, so a higher byte outweighs any lower byte in the same partition.
- R5: Mode 4 gives a < b and mode 5 gives a <= b, both unsigned over the partition's slice.
- R6: Mode 6 gives 1 when every bit of a_i inside the partition is 1.
- R7: Mode 7 gives 1 when any bit of a_i inside the partition is 1.
- R8: Mode 8 gives the XOR of all bits of a_i inside the partition.
- R9: Mode encodings 9 to 15 drive res_o to 8'h00 for any operands and gates.
- R10: With gate_i = 7'h00 the whole word is one 64-bit partition. With gate_i = 7'h7F each byte lane is compared or reduced on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | First operand; the only operand used by the reductions |
| b_i | input | 64 | Second operand for the relational modes |
| gate_i | input | 7 | Partition break between lane j and lane j+1 when bit j is 1 |
| mode_i | input | 4 | Operation select: 0 eq, 1 ne, 2 gt, 3 ge, 4 lt, 5 le, 6 all-ones, 7 any-set, 8 parity |
| res_o | output | 8 | Per-lane result; each partition's answer is repeated on all its lanes |

## Verification
All 128 gate patterns are swept under every valid mode with two operand flavours. Fully random pairs mostly exercise decisions in the top byte. Near-equal pairs differ in a single random byte, which forces the magnitude and equality chains to carry across lanes before a lower byte decides. Directed cases then set a top-byte win against a bottom-byte loss in one 64-bit partition, and repeat it with all lanes split, which separates correct chaining from per-lane answers. Bit-position cases for all-ones, any-set and parity show whether a reduction stops at the partition edge. Unused encodings and the all-equal reset pattern check the output mux.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;

    localparam int unsigned LANE_W_DEF = 8;
    localparam int unsigned LANES_DEF  = 8;

    typedef enum logic [3:0] {
        MODE_EQ  = 4'd0,
        MODE_NE  = 4'd1,
        MODE_GT  = 4'd2,
        MODE_GE  = 4'd3,
        MODE_LT  = 4'd4,
        MODE_LE  = 4'd5,
        MODE_ALL = 4'd6,
        MODE_ANY = 4'd7,
        MODE_PAR = 4'd8
    } cmp_mode_e;

    typedef enum logic [1:0] {
        FOLD_AND = 2'd0,
        FOLD_OR  = 2'd1,
        FOLD_XOR = 2'd2
    } fold_e;

endpackage

// File: rtl/simd_lane_eval.sv
module simd_lane_eval #(
    parameter int unsigned LANE_W = 8
) (
    input  logic [LANE_W-1:0] a_i,
    input  logic [LANE_W-1:0] b_i,
    output logic              eq_o,
    output logic              gt_o,
    output logic              all_o,
    output logic              any_o,
    output logic              par_o
);

    assign eq_o  = (a_i == b_i);
    assign gt_o  = (a_i > b_i);
    assign all_o = &a_i;
    assign any_o = |a_i;
    assign par_o = ^a_i;

endmodule

// File: rtl/simd_seg_reduce.sv
module simd_seg_reduce #(
    parameter int unsigned          LANES = 8,
    parameter simd_cmp_pkg::fold_e  FOLD  = simd_cmp_pkg::FOLD_AND
) (
    input  logic [LANES-1:0] lane_i,
    input  logic [LANES-2:0] gate_i,
    output logic [LANES-1:0] bcast_o
);

    // brk[j] is the break below lane j; guard breaks at both ends
    logic [LANES:0]   brk;
    logic [LANES-1:0] acc;

    assign brk = {1'b1, gate_i, 1'b1};

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        if (j == LANES - 1) begin : g_top
            assign acc[j] = lane_i[j];
        end else begin : g_inner
            logic joined;
            if (FOLD == simd_cmp_pkg::FOLD_AND) begin : g_and
                assign joined = lane_i[j] & acc[j+1];
            end else if (FOLD == simd_cmp_pkg::FOLD_OR) begin : g_or
                assign joined = lane_i[j] | acc[j+1];
            end else begin : g_xor
                assign joined = lane_i[j] ^ acc[j+1];
            end
            assign acc[j] = brk[j+1] ? lane_i[j] : joined;
        end

        if (j == 0) begin : g_base
            assign bcast_o[j] = acc[j];
        end else begin : g_up
            assign bcast_o[j] = brk[j] ? acc[j] : bcast_o[j-1];
        end
    end

endmodule

// File: rtl/simd_seg_magnitude.sv
module simd_seg_magnitude #(
    parameter int unsigned LANES = 8
) (
    input  logic [LANES-1:0] eq_i,
    input  logic [LANES-1:0] gt_i,
    input  logic [LANES-2:0] gate_i,
    output logic [LANES-1:0] eq_o,
    output logic [LANES-1:0] gt_o
);

    logic [LANES:0]   brk;
    logic [LANES-1:0] eq_acc;
    logic [LANES-1:0] gt_acc;

    assign brk = {1'b1, gate_i, 1'b1};

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        if (j == LANES - 1) begin : g_top
            assign eq_acc[j] = eq_i[j];
            assign gt_acc[j] = gt_i[j];
        end else begin : g_inner
            // higher lanes of the same partition take precedence
            assign eq_acc[j] = brk[j+1] ? eq_i[j] : (eq_i[j] & eq_acc[j+1]);
            assign gt_acc[j] = brk[j+1] ? gt_i[j]
                                        : (gt_acc[j+1] | (eq_acc[j+1] & gt_i[j]));
        end

        if (j == 0) begin : g_base
            assign eq_o[j] = eq_acc[j];
            assign gt_o[j] = gt_acc[j];
        end else begin : g_up
            assign eq_o[j] = brk[j] ? eq_acc[j] : eq_o[j-1];
            assign gt_o[j] = brk[j] ? gt_acc[j] : gt_o[j-1];
        end
    end

endmodule

// File: rtl/simd_part_cmp.sv
module simd_part_cmp
    import simd_cmp_pkg::*;
#(
    parameter int unsigned LANE_W = LANE_W_DEF,
    parameter int unsigned LANES  = LANES_DEF,
    localparam int unsigned DATA_W = LANE_W * LANES,
    localparam int unsigned GATE_W = LANES - 1
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [GATE_W-1:0] gate_i,
    input  logic [3:0]        mode_i,
    output logic [LANES-1:0]  res_o
);

    logic [LANES-1:0] l_eq, l_gt, l_all, l_any, l_par;
    logic [LANES-1:0] eq_bc, gt_bc, all_bc, any_bc, par_bc;

    for (genvar j = 0; j < LANES; j++) begin : g_eval
        simd_lane_eval #(.LANE_W(LANE_W)) u_eval (
            .a_i   (a_i[j*LANE_W +: LANE_W]),
            .b_i   (b_i[j*LANE_W +: LANE_W]),
            .eq_o  (l_eq[j]),
            .gt_o  (l_gt[j]),
            .all_o (l_all[j]),
            .any_o (l_any[j]),
            .par_o (l_par[j])
        );
    end

    simd_seg_magnitude #(.LANES(LANES)) u_mag (
        .eq_i   (l_eq),
        .gt_i   (l_gt),
        .gate_i (gate_i),
        .eq_o   (eq_bc),
        .gt_o   (gt_bc)
    );

    simd_seg_reduce #(.LANES(LANES), .FOLD(FOLD_AND)) u_all (
        .lane_i  (l_all),
        .gate_i  (gate_i),
        .bcast_o (all_bc)
    );

    simd_seg_reduce #(.LANES(LANES), .FOLD(FOLD_OR)) u_any (
        .lane_i  (l_any),
        .gate_i  (gate_i),
        .bcast_o (any_bc)
    );

    simd_seg_reduce #(.LANES(LANES), .FOLD(FOLD_XOR)) u_par (
        .lane_i  (l_par),
        .gate_i  (gate_i),
        .bcast_o (par_bc)
    );

    always_comb begin
        case (mode_i)
            MODE_EQ:  res_o = eq_bc;
            MODE_NE:  res_o = ~eq_bc;
            MODE_GT:  res_o = gt_bc;
            MODE_GE:  res_o = gt_bc | eq_bc;
            MODE_LT:  res_o = ~(gt_bc | eq_bc);
            MODE_LE:  res_o = ~gt_bc;
            MODE_ALL: res_o = all_bc;
            MODE_ANY: res_o = any_bc;
            MODE_PAR: res_o = par_bc;
            default:  res_o = '0;
        endcase
    end

endmodule

// File: rtl/simd_part_cmp_chk.sv
module simd_part_cmp_chk #(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned LANES  = 8
) (
    input logic [LANE_W*LANES-1:0] a_i,
    input logic [LANE_W*LANES-1:0] b_i,
    input logic [LANES-2:0]        gate_i,
    input logic [3:0]              mode_i,
    input logic [LANES-1:0]        res_o,
    input logic [LANES-1:0]        eq_bc,
    input logic [LANES-1:0]        gt_bc
);

    always_comb begin
        if (!$isunknown({a_i, b_i, gate_i, mode_i})) begin
            // R2: joined neighbours carry the same result bit
            a_r2_uniform: assert (((res_o ^ (res_o >> 1)) & {1'b0, ~gate_i}) == '0)
                else $error("joined lanes disagree");
            // R9: unused encodings give zero
            a_r9_unused_zero: assert (mode_i < 4'd9 || res_o == '0)
                else $error("unused mode not zero");
            // R3: identical operands compare equal everywhere
            a_r3_equal_ops: assert (mode_i != 4'd0 || a_i != b_i || &res_o)
                else $error("equal operands not reported equal");
            // R4: greater and equal chains never both claim a lane
            a_r4_gt_eq_excl: assert ((gt_bc & eq_bc) == '0)
                else $error("greater and equal both set");
            // R6: an all-ones operand is all-ones in every partition
            a_r6_all_ones: assert (mode_i != 4'd6 || !(&a_i) || &res_o)
                else $error("all-ones operand missed");
            // R7: a zero operand has no set bit in any partition
            a_r7_any_zero: assert (mode_i != 4'd7 || a_i != '0 || res_o == '0)
                else $error("zero operand reported set");
        end
    end

endmodule

bind simd_part_cmp simd_part_cmp_chk #(.LANE_W(LANE_W), .LANES(LANES)) chk_i (
    .a_i    (a_i),
    .b_i    (b_i),
    .gate_i (gate_i),
    .mode_i (mode_i),
    .res_o  (res_o),
    .eq_bc  (eq_bc),
    .gt_bc  (gt_bc)
);

// File: tb/simd_part_cmp_tb_top.sv
module simd_part_cmp_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] a, b;
    logic [6:0]  g;
    logic [3:0]  m;
    logic [7:0]  res;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    simd_part_cmp dut_i (
        .a_i    (a),
        .b_i    (b),
        .gate_i (g),
        .mode_i (m),
        .res_o  (res)
    );

    function automatic string req_of(input logic [3:0] md);
        case (md)
            4'd0, 4'd1: return "R3";
            4'd2, 4'd3: return "R4";
            4'd4, 4'd5: return "R5";
            4'd6:       return "R6";
            4'd7:       return "R7";
            4'd8:       return "R8";
            default:    return "R9";
        endcase
    endfunction

    // behavioural model: walk partitions, compare shifted slices
    function automatic logic [7:0] ref_model(input logic [63:0] ra, input logic [63:0] rb,
                                             input logic [6:0] rg, input logic [3:0] md);
        logic [7:0]  r;
        logic [63:0] mask, x, y;
        logic        bit_v;
        int          k, w;
        r = '0;
        k = 0;
        while (k < 8) begin
            w = 1;
            while (k + w < 8 && !rg[k+w-1]) w++;
            mask = (w == 8) ? {64{1'b1}} : ((64'd1 << (8*w)) - 64'd1);
            x = (ra >> (8*k)) & mask;
            y = (rb >> (8*k)) & mask;
            case (md)
                4'd0: bit_v = (x == y);
                4'd1: bit_v = (x != y);
                4'd2: bit_v = (x > y);
                4'd3: bit_v = (x >= y);
                4'd4: bit_v = (x < y);
                4'd5: bit_v = (x <= y);
                4'd6: bit_v = (x == mask);
                4'd7: bit_v = (x != 64'd0);
                4'd8: bit_v = ^x;
                default: bit_v = 1'b0;
            endcase
            for (int j = 0; j < w; j++) r[k+j] = bit_v;
            k += w;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b (gate %b mode %0d a %h b %h)",
                     tag, got, exp, g, m, a, b);
        end
    endtask

    task automatic apply(input logic [63:0] ta, input logic [63:0] tb,
                         input logic [6:0] tg, input logic [3:0] tm);
        @(posedge clk);
        a <= ta; b <= tb; g <= tg; m <= tm;
        @(negedge clk);
    endtask

    task automatic run_ref(input string tag, input logic [63:0] ta, input logic [63:0] tb,
                           input logic [6:0] tg, input logic [3:0] tm);
        apply(ta, tb, tg, tm);
        check(tag, res, ref_model(ta, tb, tg, tm));
    endtask

    task automatic t_reset_state;
        rst = 1'b1;
        a = '0; b = '0; g = '0; m = 4'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R3 reset state eq of zeros", res, 8'hFF);
        rst = 1'b0;
    endtask

    // R1 R2: every gate pattern under every valid mode
    task automatic t_gate_sweep;
        for (int gp = 0; gp < 128; gp++) begin
            for (int md = 0; md < 9; md++) begin
                logic [63:0] ra, rb;
                int          pos;
                ra = {$urandom, $urandom};
                rb = {$urandom, $urandom};
                run_ref({"R1 R2 random ", req_of(md[3:0])}, ra, rb, gp[6:0], md[3:0]);
                pos = $urandom_range(7, 0);
                rb = ra;
                rb[pos*8 +: 8] = 8'($urandom);
                if (md == 6 || md == 8) ra[pos*8 +: 8] = 8'hFF;
                run_ref({"R1 R2 near-equal ", req_of(md[3:0])}, ra, rb, gp[6:0], md[3:0]);
            end
        end
    endtask

    task automatic t_magnitude;
        apply(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 7'h00, 4'd2);
        check("R4 top byte wins gt", res, 8'hFF);
        apply(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 7'h7F, 4'd2);
        check("R4 split lanes gt", res, 8'h80);
        apply(64'h0000_0000_0000_0005, 64'h0000_0000_0000_0005, 7'h00, 4'd3);
        check("R4 ge on equal", res, 8'hFF);
        apply(64'h1234_5678_0000_0001, 64'h1234_5678_0000_0002, 7'h00, 4'd4);
        check("R5 lt decided by low byte", res, 8'hFF);
        apply(64'h1234_5678_0000_0001, 64'h1234_5678_0000_0002, 7'h00, 4'd5);
        check("R5 le", res, 8'hFF);
        apply(64'h1234_5678_0000_0001, 64'h1234_5678_0000_0002, 7'h00, 4'd1);
        check("R3 ne", res, 8'hFF);
    endtask

    task automatic t_reductions;
        apply({64{1'b1}}, '0, 7'h00, 4'd6);
        check("R6 all ones word", res, 8'hFF);
        apply(64'hFFFF_FFFF_FFFF_FFFE, '0, 7'h00, 4'd6);
        check("R6 one zero bit", res, 8'h00);
        apply(64'hFFFF_FFFF_FFFF_FFFE, '0, 7'h01, 4'd6);
        check("R6 zero bit isolated", res, 8'hFE);
        apply(64'h8000_0000_0000_0000, '0, 7'h00, 4'd7);
        check("R7 top bit whole word", res, 8'hFF);
        apply(64'h8000_0000_0000_0000, '0, 7'h7F, 4'd7);
        check("R7 top bit split", res, 8'h80);
        apply(64'h0000_0000_0000_0301, '0, 7'h7F, 4'd8);
        check("R8 parity split", res, 8'h01);
        apply(64'h0000_0000_0000_0301, '0, 7'h00, 4'd8);
        check("R8 parity whole", res, 8'hFF);
    endtask

    task automatic t_unused;
        for (int md = 9; md < 16; md++) begin
            apply({$urandom, $urandom}, {$urandom, $urandom}, 7'($urandom), md[3:0]);
            check("R9 unused mode", res, 8'h00);
        end
    endtask

    task automatic t_extremes;
        apply(64'hAA00_0000_0000_0000, 64'h5500_0000_0000_0000, 7'h00, 4'd0);
        check("R10 single partition eq", res, 8'h00);
        apply(64'hAA00_0000_0000_0000, 64'h5500_0000_0000_0000, 7'h7F, 4'd0);
        check("R10 eight lanes eq", res, 8'h7F);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_gate_sweep();
        t_magnitude();
        t_reductions();
        t_unused();
        t_extremes();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule